// File: doc/BRIEF.md
# Recirculating Loop Pipeline

This block is a valid/ready pipeline segment that runs an operation through the same compute stages more than once. An operation enters a setup register, passes a loop header register, crosses a chain of compute stages and reaches a footer. At the footer it either returns to the header for another pass or moves into the finish register, which drives the output. The width class of the operation sets how many passes it takes. A small pass counter travels with the operation, separate from its tag.

The header always gives the returning operation the slot. In that cycle new work cannot move forward, so ready to the upstream side is low. A returning operation cannot be refused, so the compute stages keep moving whenever the footer sends something back. A cancel bus carries a tag. Every stage that holds an operation with that tag drops it in the same cycle, so a cancelled operation neither loops again nor appears at the output.

Top module: `recirc_loop_pipe`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `in_width` encodes 0 = 8-bit and 1 = 16-bit (one pass), 2 = 32-bit (two passes) and 3 = 64-bit (four passes). Each pass adds 3 to the data, one per compute stage, so the result is `in_data + 3*passes` modulo 2^DW.
- R3: With no other traffic and `out_ready` high, `out_valid` rises with the result 4*passes+1 clock edges after the edge that accepted the operation.
- R4: In any cycle where the footer returns an operation to the header, `in_ready` is 0 and a full setup register keeps its contents.
- R5: On each return the footer lowers the pass counter by one. The returning operation is in the header on the next cycle with that counter and its tag unchanged.
- R6: While the footer returns an operation, the compute stages advance in that cycle, and each stage adds 1 to the data it takes in.
- R7: When `cancel_valid` is high, every operation whose tag equals `cancel_tag` is dropped from every stage in that cycle and never shows up at the output. Operations with other tags are not affected.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_tag` hold steady. No operation is lost under back-pressure.
- R9: `out_tag` is the tag the operation was accepted with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New operation offered |
| in_ready | output | 1 | Setup can accept this cycle |
| in_width | input | 2 | Width class (0:8, 1:16, 2:32, 3:64 bit) |
| in_tag | input | TW | Operation tag |
| in_data | input | DW | Operand |
| cancel_valid | input | 1 | Cancel strobe |
| cancel_tag | input | TW | Tag to cancel |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream accepts result |
| out_tag | output | TW | Tag of the result |
| out_data | output | DW | Result data |

## Verification
Single operations of each width class are sent through an otherwise empty pipeline. Exact latency and result tell the one-, two- and four-pass paths apart, and a value close to full scale shows the result wraps. Back-to-back mixed widths force the header to choose between returning and new work, which shows up as stalls on the input and as results leaving out of order. Cancels sent in the middle of a loop and at a stalled output show that a cancel removes only the operation it targets, and random output back-pressure over several batches shows that nothing is lost or duplicated.

// File: rtl/recirc_loop_pipe.sv
module recirc_loop_pipe #(
  parameter int DW    = 16,
  parameter int TW    = 4,
  parameter int NCOMP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_width,
  input  logic [TW-1:0] in_tag,
  input  logic [DW-1:0] in_data,
  input  logic          cancel_valid,
  input  logic [TW-1:0] cancel_tag,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [TW-1:0] out_tag,
  output logic [DW-1:0] out_data
);
  localparam int LAST = NCOMP - 1;

  logic          s_valid, h_valid, f_valid;
  logic [1:0]    s_cnt, h_cnt;
  logic [TW-1:0] s_tag, h_tag, f_tag;
  logic [DW-1:0] s_data, h_data, f_data;

  logic          c_valid [NCOMP];
  logic [1:0]    c_cnt   [NCOMP];
  logic [TW-1:0] c_tag   [NCOMP];
  logic [DW-1:0] c_data  [NCOMP];

  function automatic logic hit(input logic [TW-1:0] t);
    return cancel_valid && (t == cancel_tag);
  endfunction

  logic last_live, recirc, fwd, f_live, advance;

  assign last_live = c_valid[LAST] && !hit(c_tag[LAST]);
  assign recirc    = last_live && (c_cnt[LAST] != 2'd0);
  assign fwd       = last_live && (c_cnt[LAST] == 2'd0);
  assign f_live    = f_valid && !hit(f_tag);
  assign advance   = !(fwd && f_live && !out_ready);
  assign in_ready  = !recirc && (!s_valid || advance);

  assign out_valid = f_live;
  assign out_tag   = f_tag;
  assign out_data  = f_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
    end else if (in_valid && in_ready) begin
      s_valid <= !hit(in_tag);
      s_cnt   <= in_width[1] ? (in_width[0] ? 2'd3 : 2'd1) : 2'd0;
      s_tag   <= in_tag;
      s_data  <= in_data;
    end else if (advance && !recirc) begin
      s_valid <= 1'b0;
    end else begin
      s_valid <= s_valid && !hit(s_tag);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_valid <= 1'b0;
    end else if (advance) begin
      if (recirc) begin
        h_valid <= 1'b1;
        h_cnt   <= c_cnt[LAST] - 2'd1;
        h_tag   <= c_tag[LAST];
        h_data  <= c_data[LAST];
      end else begin
        h_valid <= s_valid && !hit(s_tag);
        h_cnt   <= s_cnt;
        h_tag   <= s_tag;
        h_data  <= s_data;
      end
    end else begin
      h_valid <= h_valid && !hit(h_tag);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NCOMP; k++) begin
      if (!rst_n) begin
        c_valid[k] <= 1'b0;
      end else if (advance) begin
        if (k == 0) begin
          c_valid[k] <= h_valid && !hit(h_tag);
          c_cnt[k]   <= h_cnt;
          c_tag[k]   <= h_tag;
          c_data[k]  <= h_data + DW'(1);
        end else begin
          c_valid[k] <= c_valid[k-1] && !hit(c_tag[k-1]);
          c_cnt[k]   <= c_cnt[k-1];
          c_tag[k]   <= c_tag[k-1];
          c_data[k]  <= c_data[k-1] + DW'(1);
        end
      end else begin
        c_valid[k] <= c_valid[k] && !hit(c_tag[k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_valid <= 1'b0;
    end else if (fwd && advance) begin
      f_valid <= 1'b1;
      f_tag   <= c_tag[LAST];
      f_data  <= c_data[LAST];
    end else begin
      f_valid <= f_live && !out_ready;
    end
  end
endmodule

module recirc_loop_pipe_chk #(
  parameter int DW = 16,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [TW-1:0] out_tag,
  input logic [DW-1:0] out_data,
  input logic          cancel_valid,
  input logic [TW-1:0] cancel_tag,
  input logic          s_valid,
  input logic [TW-1:0] s_tag,
  input logic          h_valid,
  input logic [1:0]    h_cnt,
  input logic [TW-1:0] h_tag,
  input logic          lv,
  input logic [1:0]    lcnt,
  input logic [TW-1:0] ltag,
  input logic [DW-1:0] ldata,
  input logic [TW-1:0] ptag,
  input logic [DW-1:0] pdata,
  input logic          f_valid,
  input logic [TW-1:0] f_tag
);
  logic back, lhit, shit;
  assign lhit = cancel_valid && (ltag == cancel_tag);
  assign shit = cancel_valid && (s_tag == cancel_tag);
  assign back = lv && !lhit && (lcnt != 2'd0);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready)); // R1
  AST_NEW_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (back && s_valid && !shit) |=> (s_valid && $stable(s_tag) && !$past(in_ready))); // R4
  AST_BACK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    back |=> (h_valid && h_cnt == $past(lcnt) - 2'd1 && h_tag == $past(ltag))); // R5
  AST_COMPUTE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    back |=> (ldata == $past(pdata) + DW'(1) && ltag == $past(ptag))); // R6
  AST_CANCEL_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lv && lhit) |=> !(f_valid && f_tag == $past(ltag))); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_tag))); // R8
endmodule

bind recirc_loop_pipe recirc_loop_pipe_chk #(.DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data),
  .cancel_valid(cancel_valid), .cancel_tag(cancel_tag),
  .s_valid(s_valid), .s_tag(s_tag),
  .h_valid(h_valid), .h_cnt(h_cnt), .h_tag(h_tag),
  .lv(c_valid[LAST]), .lcnt(c_cnt[LAST]), .ltag(c_tag[LAST]), .ldata(c_data[LAST]),
  .ptag(c_tag[LAST-1]), .pdata(c_data[LAST-1]),
  .f_valid(f_valid), .f_tag(f_tag)
);

// File: tb/test_recirc_loop_pipe.sv
`timescale 1ns/1ps
module test_recirc_loop_pipe;
  localparam int DW = 16, TW = 4, NT = 16;

  logic          clk = 0, rst_n = 0;
  logic          in_valid = 0, in_ready;
  logic [1:0]    in_width = 0;
  logic [TW-1:0] in_tag = 0;
  logic [DW-1:0] in_data = 0;
  logic          cancel_valid = 0;
  logic [TW-1:0] cancel_tag = 0;
  logic          out_valid, out_ready = 1;
  logic [TW-1:0] out_tag;
  logic [DW-1:0] out_data;

  recirc_loop_pipe #(.DW(DW), .TW(TW), .NCOMP(3)) i_recirc_loop_pipe (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, stalls = 0;
  bit rand_rdy = 0, rdy_force = 1;
  bit exp_pend [NT];
  bit lat_on [NT];
  int exp_data [NT];
  int exp_p [NT];
  int acc_cyc [NT];
  int seen [NT];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= rand_rdy ? 1'($urandom % 2) : rdy_force;
    if (cyc > 60000) begin
      chk(0, "WATCHDOG", "cycles", cyc, 60000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      int t;
      t = int'(out_tag);
      seen[t]++;
      chk(exp_pend[t], "R9", "result tag is pending", t, t);
      if (exp_pend[t]) begin
        chk(int'(out_data) == exp_data[t], "R2", "result data", int'(out_data), exp_data[t]);
        if (lat_on[t])
          chk(cyc - acc_cyc[t] == 4 * exp_p[t] + 2, "R3", "latency", cyc - acc_cyc[t], 4 * exp_p[t] + 2);
      end
      exp_pend[t] = 0;
    end
  end

  task automatic send(int t, int w, int d, bit lat);
    int p;
    @(negedge clk);
    p = (w == 3) ? 4 : (w == 2) ? 2 : 1;
    in_valid = 1; in_tag = TW'(t); in_width = 2'(w); in_data = DW'(d);
    exp_pend[t] = 1; lat_on[t] = lat; exp_p[t] = p; seen[t] = 0;
    exp_data[t] = (d + 3 * p) % (1 << DW);
    #2;
    while (!in_ready) begin
      stalls++;
      @(negedge clk); #2;
    end
    @(posedge clk);
    acc_cyc[t] = cyc;
    #1 in_valid = 0;
  endtask

  task automatic cancel(int t);
    @(negedge clk);
    cancel_valid = 1; cancel_tag = TW'(t); exp_pend[t] = 0;
    @(negedge clk);
    cancel_valid = 0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 3000; n++) begin
      bit busy;
      busy = 0;
      for (int i = 0; i < NT; i++) if (exp_pend[i]) busy = 1;
      if (!busy) break;
      @(negedge clk);
    end
    repeat (30) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NT; i++) begin exp_pend[i] = 0; seen[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

    for (int w = 0; w < 4; w++) begin
      send(w, w, 100 * w + 7, 1);
      wait_idle();
    end
    send(4, 3, 16'hFFFA, 1);
    wait_idle();
    chk(seen[4] == 1, "R2", "wrapped result delivered", seen[4], 1);

    stalls = 0;
    send(1, 3, 11, 0); send(2, 0, 22, 0); send(3, 2, 33, 0);
    send(4, 1, 44, 0); send(5, 0, 55, 0); send(6, 3, 66, 0);
    wait_idle();
    chk(stalls > 0, "R4", "input stalled by returning work", stalls, 1);
    for (int i = 1; i <= 6; i++)
      chk(seen[i] == 1, "R4", "mixed op delivered once", seen[i], 1);

    send(5, 3, 500, 0);
    send(6, 3, 600, 0);
    repeat (4) @(negedge clk);
    cancel(5);
    wait_idle();
    chk(seen[5] == 0, "R7", "cancelled op outputs", seen[5], 0);
    chk(seen[6] == 1, "R7", "other op outputs", seen[6], 1);

    rdy_force = 0;
    send(7, 0, 70, 0);
    repeat (10) @(negedge clk);
    #2;
    chk(out_valid, "R8", "result waits under back-pressure", int'(out_valid), 1);
    begin
      int d0;
      d0 = int'(out_data);
      repeat (3) @(negedge clk);
      #2;
      chk(int'(out_data) == d0 && out_valid, "R8", "held data", int'(out_data), d0);
    end
    cancel(7);
    #2;
    chk(!out_valid, "R7", "cancel at stalled output", int'(out_valid), 0);
    rdy_force = 1;
    repeat (10) @(negedge clk);
    chk(seen[7] == 0, "R7", "cancelled stalled op outputs", seen[7], 0);

    rand_rdy = 1;
    for (int r = 0; r < 3; r++) begin
      for (int t = 0; t < 12; t++)
        send(t, int'($urandom % 4), int'($urandom % 65536), 0);
      wait_idle();
      for (int t = 0; t < 12; t++)
        chk(seen[t] == 1, "R8", "random batch delivered once", seen[t], 1);
    end
    rand_rdy = 0;
    finish_run();
  end
endmodule